// File: doc/BRIEF.md
# Acquisition Capture Sequencer

This block runs one acquisition into a circular sample memory. Software programs a control byte and a post-trigger row count through a small write port. The block then gates the memory writer, waits for a trigger, and lets capture run on for the programmed number of rows. Capture then stops by itself. A forced stop ends it early. Software can also fire the trigger itself. A separate memory-initialise strobe is passed on as a one-cycle pulse.

The sample writer supplies the current 24-bit write address. The upper 15 bits of that address are the row and the lower 9 bits are the word within the row. The block watches the row field to count rows after the trigger and to detect a rollover from the last row back to row 0. It captures the address at the trigger and at the stop. Software reads these back through a byte-wide read port, low byte first. The same read port also returns a status byte.

Top module: `capture_sequencer`

## Requirements
- R1: After reset, the write enable, read enable and mem_init outputs are low, the status byte (read address 7) is 0x00 and every position byte reads 0x00.
- R2: A write to address 3 loads write enable from bit 0, read enable from bit 1 and trigger enable from bit 3. The status byte shows them at bits 0, 1 and 3, and mem_wr_en/mem_rd_en follow them.
- R3: A trig_hit pulse counts only while trigger enable and write enable are both set and no trigger has yet been taken. It records cur_addr as the trigger position, readable low/high/upper at read addresses 1, 2, 3, and sets status bit 5. Later pulses leave the position unchanged.
- R4: After the trigger, once cur_addr has moved into a new row N times (N written at address 5), the block acts on the following cycle. It sets status bit 6, clears write enable and records cur_addr as the stop position at read addresses 4, 5, 6. With N = 0 this happens one cycle after the trigger.
- R5: Control bit 2 clears the triggered, post-trigger-done and wrap flags. A trigger in the same cycle is not taken.
- R6: While write enable is set, a change of cur_addr from row 0x7FFF to row 0 sets status bit 4.
- R7: Control bit 4 (force stop) clears write enable whatever bit 0 says. If capture was running, it records cur_addr as the stop position.
- R8: Control bit 5 acts as a trigger pulse. It is judged against the trigger and write enables held before that write.
- R9: Control bit 7 produces a single-cycle pulse on mem_init in the cycle after the write.
- R10: Read addresses 0 and 8 to 15 return 0x00, and status bits 2 and 7 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Write address (3 control, 5 post-trigger rows) |
| reg_wdata | input | 8 | Write data |
| reg_raddr | input | 4 | Read address |
| reg_rdata | output | 8 | Read data, combinational from reg_raddr |
| trig_hit | input | 1 | Trigger-match pulse from the trigger unit |
| cur_addr | input | 24 | Current sample-memory write address |
| mem_wr_en | output | 1 | Memory write enable (capture running) |
| mem_rd_en | output | 1 | Memory read enable |
| mem_init | output | 1 | Memory initialise pulse |

## Verification
Each write, each trig_hit pulse and each row change takes effect at the next rising edge. The read port is combinational, so any register value can be read in the half cycle that follows that edge. The one exception is the post-trigger stop: it lands one edge after the final row change is seen, and one edge after the trigger when N is zero. The bench therefore waits at least two idle cycles after each address move before it queues a read expectation. It holds all stimulus quiet while the monitor samples two nanoseconds after the next edge. The mem_init pulse is checked at the falling edge right after the writing cycle, and again one cycle later.

// File: rtl/capseq_pkg.sv
package capseq_pkg;
  localparam int ADDR_W  = 24;
  localparam int WORD_W  = 9;
  localparam int POST_W  = 8;
  localparam int RADDR_W = 4;

  localparam logic [RADDR_W-1:0] CTRL_REG = 4'd3;
  localparam logic [RADDR_W-1:0] POST_REG = 4'd5;

  localparam int CB_WEN   = 0;
  localparam int CB_REN   = 1;
  localparam int CB_TRST  = 2;
  localparam int CB_TEN   = 3;
  localparam int CB_FSTOP = 4;
  localparam int CB_SWT   = 5;
  localparam int CB_INIT  = 7;

  localparam int RD_TRIG_BASE = 1;
  localparam int RD_STOP_BASE = 4;
  localparam int RD_STATUS    = 7;

  typedef struct packed {
    logic post_done;
    logic triggered;
    logic wrapped;
    logic trig_en;
    logic rd_en;
    logic wr_en;
  } cap_flags_t;

  function automatic logic [7:0] pack_status(input cap_flags_t f);
    return {1'b0, f.post_done, f.triggered, f.wrapped, f.trig_en, 1'b0, f.rd_en, f.wr_en};
  endfunction
endpackage

// File: rtl/capseq_ctrl_regs.sv
module capseq_ctrl_regs
  import capseq_pkg::*;
#(
  parameter int PW  = POST_W,
  parameter int RAW = RADDR_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [RAW-1:0] waddr,
  input  logic [7:0]     wdata,
  input  logic           stop_evt,
  output logic           wr_en,
  output logic           rd_en,
  output logic           trig_en,
  output logic [PW-1:0]  post_rows,
  output logic           trig_rst_stb,
  output logic           force_stb,
  output logic           sw_trig_stb,
  output logic           init_pulse
);
  logic ctrl_we, post_we;
  logic unused_bit6;

  assign ctrl_we      = we && (waddr == RAW'(CTRL_REG));
  assign post_we      = we && (waddr == RAW'(POST_REG));
  assign trig_rst_stb = ctrl_we && wdata[CB_TRST];
  assign force_stb    = ctrl_we && wdata[CB_FSTOP];
  assign sw_trig_stb  = ctrl_we && wdata[CB_SWT];
  assign unused_bit6  = wdata[6];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en      <= 1'b0;
      rd_en      <= 1'b0;
      trig_en    <= 1'b0;
      post_rows  <= '0;
      init_pulse <= 1'b0;
    end else begin
      init_pulse <= ctrl_we && wdata[CB_INIT];
      if (post_we) post_rows <= PW'(wdata);
      if (ctrl_we) begin
        wr_en   <= wdata[CB_WEN] && !wdata[CB_FSTOP];
        rd_en   <= wdata[CB_REN];
        trig_en <= wdata[CB_TEN];
      end else if (stop_evt) begin
        wr_en <= 1'b0;
      end
    end
  end

  // R7: force stop leaves write enable low
  a_r7_force_clears_wen: assert property (@(posedge clk) disable iff (!rst_n)
    force_stb |=> !wr_en);
  // R9: a memory-init pulse only follows a write with the init bit
  a_r9_init_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    init_pulse |-> $past(ctrl_we && wdata[CB_INIT]));
endmodule

// File: rtl/capseq_track.sv
module capseq_track
  import capseq_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int WB = WORD_W,
  parameter int PW = POST_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cur_addr,
  input  logic          trig_hit,
  input  logic          sw_trig_stb,
  input  logic          trig_rst_stb,
  input  logic          force_stb,
  input  logic          wr_en,
  input  logic          trig_en,
  input  logic [PW-1:0] post_rows,
  output logic          stop_evt,
  output logic          triggered,
  output logic          post_done,
  output logic          wrapped,
  output logic [AW-1:0] trig_pos,
  output logic [AW-1:0] stop_pos
);
  localparam int RW = AW - WB;

  function automatic logic [RW-1:0] row_of(input logic [AW-1:0] a);
    return a[AW-1:WB];
  endfunction

  logic [RW-1:0] prev_row, cur_row;
  logic [PW-1:0] remaining;
  logic          row_step, wrap_evt, fire, counting;

  assign cur_row  = row_of(cur_addr);
  assign row_step = (cur_row != prev_row);
  assign wrap_evt = (prev_row == '1) && (cur_row == '0);
  assign fire     = trig_en && wr_en && !triggered && !trig_rst_stb
                    && (trig_hit || sw_trig_stb);
  assign counting = triggered && !post_done && wr_en;
  assign stop_evt = counting && (remaining == '0) && !trig_rst_stb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_row  <= '0;
      remaining <= '0;
      triggered <= 1'b0;
      post_done <= 1'b0;
      wrapped   <= 1'b0;
      trig_pos  <= '0;
      stop_pos  <= '0;
    end else begin
      prev_row <= cur_row;
      if (trig_rst_stb) begin
        triggered <= 1'b0;
        post_done <= 1'b0;
        wrapped   <= 1'b0;
      end else begin
        if (fire) begin
          triggered <= 1'b1;
          trig_pos  <= cur_addr;
          remaining <= post_rows;
        end
        if (stop_evt) begin
          post_done <= 1'b1;
          stop_pos  <= cur_addr;
        end else if (counting && row_step) begin
          remaining <= remaining - 1'b1;
        end
        if (wrap_evt && wr_en) wrapped <= 1'b1;
      end
      if (force_stb && wr_en && !stop_evt) stop_pos <= cur_addr;
    end
  end

  // R3: trigger position holds while the trigger stays taken
  a_r3_pos_hold: assert property (@(posedge clk) disable iff (!rst_n)
    triggered && $past(triggered) |-> $stable(trig_pos));
  // R3: a trigger is only taken while armed and capturing
  a_r3_armed_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(triggered) |-> $past(trig_en && wr_en));
  // R4: completion implies a trigger
  a_r4_done_after_trig: assert property (@(posedge clk) disable iff (!rst_n)
    post_done |-> triggered);
  // R5: trigger reset clears every flag
  a_r5_reset_flags: assert property (@(posedge clk) disable iff (!rst_n)
    trig_rst_stb |=> !triggered && !post_done && !wrapped);
  // R6: rollover while writing raises the wrap flag
  a_r6_wrap_seen: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt && wr_en && !trig_rst_stb |=> wrapped);
endmodule

// File: rtl/capture_sequencer.sv
module capture_sequencer
  import capseq_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int WB  = WORD_W,
  parameter int PW  = POST_W,
  parameter int RAW = RADDR_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_waddr,
  input  logic [7:0]     reg_wdata,
  input  logic [RAW-1:0] reg_raddr,
  output logic [7:0]     reg_rdata,
  input  logic           trig_hit,
  input  logic [AW-1:0]  cur_addr,
  output logic           mem_wr_en,
  output logic           mem_rd_en,
  output logic           mem_init
);
  localparam int NB = (AW + 7) / 8;

  logic          wr_en, rd_en, trig_en, stop_evt;
  logic          trig_rst_stb, force_stb, sw_trig_stb;
  logic          triggered, post_done, wrapped;
  logic [PW-1:0] post_rows;
  logic [AW-1:0] trig_pos, stop_pos;
  logic [NB*8-1:0] trig_ext, stop_ext;
  logic [7:0]    trig_b [NB];
  logic [7:0]    stop_b [NB];
  cap_flags_t    flags;

  capseq_ctrl_regs #(.PW(PW), .RAW(RAW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(reg_waddr), .wdata(reg_wdata),
    .stop_evt(stop_evt), .wr_en(wr_en), .rd_en(rd_en), .trig_en(trig_en),
    .post_rows(post_rows), .trig_rst_stb(trig_rst_stb), .force_stb(force_stb),
    .sw_trig_stb(sw_trig_stb), .init_pulse(mem_init)
  );

  capseq_track #(.AW(AW), .WB(WB), .PW(PW)) u_track (
    .clk(clk), .rst_n(rst_n), .cur_addr(cur_addr), .trig_hit(trig_hit),
    .sw_trig_stb(sw_trig_stb), .trig_rst_stb(trig_rst_stb), .force_stb(force_stb),
    .wr_en(wr_en), .trig_en(trig_en), .post_rows(post_rows), .stop_evt(stop_evt),
    .triggered(triggered), .post_done(post_done), .wrapped(wrapped),
    .trig_pos(trig_pos), .stop_pos(stop_pos)
  );

  assign trig_ext = (NB*8)'(trig_pos);
  assign stop_ext = (NB*8)'(stop_pos);

  for (genvar i = 0; i < NB; i++) begin : g_bytes
    assign trig_b[i] = trig_ext[8*i +: 8];
    assign stop_b[i] = stop_ext[8*i +: 8];
  end

  assign flags     = '{post_done: post_done, triggered: triggered, wrapped: wrapped,
                       trig_en: trig_en, rd_en: rd_en, wr_en: wr_en};
  assign mem_wr_en = wr_en;
  assign mem_rd_en = rd_en;

  always_comb begin
    reg_rdata = 8'h00;
    for (int i = 0; i < NB; i++) begin
      if (int'(reg_raddr) == RD_TRIG_BASE + i) reg_rdata = trig_b[i];
      if (int'(reg_raddr) == RD_STOP_BASE + i) reg_rdata = stop_b[i];
    end
    if (int'(reg_raddr) == RD_STATUS) reg_rdata = pack_status(flags);
  end

  // R10: reserved status bits never set
  a_r10_status_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(reg_raddr) == RD_STATUS) |-> (reg_rdata[7] == 1'b0 && reg_rdata[2] == 1'b0));
  // R2: memory enables mirror the status byte
  a_r2_enables_match: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(reg_raddr) == RD_STATUS) |-> (reg_rdata[0] == mem_wr_en && reg_rdata[1] == mem_rd_en));
endmodule

// File: tb/sim_capture_sequencer.sv
module sim_capture_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_waddr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [3:0]  reg_raddr = '0;
  logic [7:0]  reg_rdata;
  logic        trig_hit = 1'b0;
  logic [23:0] cur_addr = '0;
  logic        mem_wr_en, mem_rd_en, mem_init;

  int total = 0;
  int bad = 0;
  bit done_flag = 1'b0;

  logic [3:0] sb_a[$];
  logic [7:0] sb_e[$];
  string      sb_t[$];

  always #4 clk = ~clk;

  capture_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .trig_hit(trig_hit), .cur_addr(cur_addr), .mem_wr_en(mem_wr_en),
    .mem_rd_en(mem_rd_en), .mem_init(mem_init)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver side of the scoreboard: select a read address and queue its expectation
  task automatic expect_rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    reg_raddr = a;
    sb_a.push_back(a);
    sb_e.push_back(e);
    sb_t.push_back(tag);
  endtask

  task automatic expect_pos(input logic [3:0] base, input logic [23:0] v, input string tag);
    expect_rd(base,        v[7:0],   tag);
    expect_rd(base + 4'd1, v[15:8],  tag);
    expect_rd(base + 4'd2, v[23:16], tag);
  endtask

  task automatic drain();
    while (sb_e.size() > 0) @(negedge clk);
  endtask

  task automatic wreg(input logic [3:0] a, input logic [7:0] d);
    drain();
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pulse_hit();
    drain();
    @(negedge clk); trig_hit = 1'b1;
    @(negedge clk); trig_hit = 1'b0;
  endtask

  task automatic move(input logic [23:0] a);
    drain();
    @(negedge clk); cur_addr = a;
    repeat (3) @(negedge clk);
  endtask

  // monitor side: compare after the edge that follows each queued read
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_e.size() > 0) begin
        logic [3:0] a;
        logic [7:0] e;
        string t;
        a = sb_a.pop_front();
        e = sb_e.pop_front();
        t = sb_t.pop_front();
        chk($sformatf("%s rd[%0d]", t, a), {24'h0, reg_rdata}, {24'h0, e});
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!done_flag) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cur_addr = 24'h012345;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 wr_en", {31'h0, mem_wr_en}, 32'h0);
    chk("R1 init", {31'h0, mem_init}, 32'h0);
    expect_rd(4'd7, 8'h00, "R1 status");
    expect_pos(4'd1, 24'h000000, "R1 trigpos");
    // R2 enables
    wreg(4'd5, 8'd2);
    wreg(4'd3, 8'h0B);
    chk("R2 mem_wr_en", {31'h0, mem_wr_en}, 32'h1);
    chk("R2 mem_rd_en", {31'h0, mem_rd_en}, 32'h1);
    expect_rd(4'd7, 8'h0B, "R2 status");
    // R3 trigger latch
    pulse_hit();
    expect_rd(4'd7, 8'h2B, "R3 status");
    expect_pos(4'd1, 24'h012345, "R3 trigpos");
    move(24'h012346);
    pulse_hit();
    expect_pos(4'd1, 24'h012345, "R3 second hit ignored");
    // R4 post-trigger rows
    move(24'h012546);
    expect_rd(4'd7, 8'h2B, "R4 one row not done");
    move(24'h012746);
    expect_rd(4'd7, 8'h6A, "R4 done status");
    expect_pos(4'd4, 24'h012746, "R4 stoppos");
    drain();
    chk("R4 wr_en off", {31'h0, mem_wr_en}, 32'h0);
    // R5 trigger reset
    wreg(4'd3, 8'h0F);
    expect_rd(4'd7, 8'h0B, "R5 flags cleared");
    // R6 wrap
    move(24'hFFFE00);
    move(24'h000010);
    expect_rd(4'd7, 8'h1B, "R6 wrap");
    // R7 force stop
    wreg(4'd3, 8'h1B);
    expect_rd(4'd7, 8'h1A, "R7 status");
    expect_pos(4'd4, 24'h000010, "R7 stoppos");
    drain();
    chk("R7 wr_en off", {31'h0, mem_wr_en}, 32'h0);
    // R8 software trigger
    wreg(4'd3, 8'h0F);
    move(24'h0ABCDE);
    wreg(4'd3, 8'h2B);
    expect_rd(4'd7, 8'h2B, "R8 status");
    expect_pos(4'd1, 24'h0ABCDE, "R8 trigpos");
    // R3 disabled trigger ignored, R5 reset clears flags
    wreg(4'd3, 8'h07);
    move(24'h000200);
    pulse_hit();
    expect_rd(4'd7, 8'h03, "R3 disabled status");
    expect_rd(4'd1, 8'hDE, "R3 disabled pos");
    // R4 zero post rows
    wreg(4'd5, 8'd0);
    wreg(4'd3, 8'h0F);
    pulse_hit();
    repeat (2) @(negedge clk);
    expect_rd(4'd7, 8'h6A, "R4 zero rows status");
    expect_pos(4'd4, 24'h000200, "R4 zero rows stoppos");
    // R9 init pulse
    drain();
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = 4'd3; reg_wdata = 8'h80;
    @(negedge clk);
    reg_we = 1'b0;
    chk("R9 pulse high", {31'h0, mem_init}, 32'h1);
    @(negedge clk);
    chk("R9 pulse low", {31'h0, mem_init}, 32'h0);
    expect_rd(4'd7, 8'h60, "R9 status after init write");
    // R10 unused reads
    expect_rd(4'd0, 8'h00, "R10 addr0");
    expect_rd(4'd8, 8'h00, "R10 addr8");
    expect_rd(4'd15, 8'h00, "R10 addr15");
    drain();
    repeat (2) @(negedge clk);
    done_flag = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule